// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Rank-Based Replacement

This block caches leaf page-table entries so that a 32-bit virtual address can be turned into a physical address without walking the page table. Each lookup compares the virtual page number (VPN) against every stored entry at once. On a hit the block returns the physical page number (PPN), joined to the 12-bit page offset, together with the entry's dirty bit. On a miss it raises a one-cycle miss pulse. The exception logic uses this pulse to restart the faulting instruction after the page-table walk has refilled the buffer. A user-mode request into the kernel half of the address space is refused. A write to a clean page raises a modify exception.

Refill writes one entry per cycle. The slot it writes is chosen in this order. First, a slot that already holds the same VPN. Next, the lowest-indexed empty slot. Last, the slot with the lowest rank value, taking the lowest index on a tie. Each entry carries a small saturating rank. A hit sets the rank of the entry it used to the maximum and lowers every other valid entry by one. A flush empties the whole buffer in one cycle.

Lookup results are registered. They appear in the cycle after the request has been sampled. The refill and flush inputs act at the same clock edge.

Top module: `tlb_ref_lru`

## Requirements
- R1: A lookup whose VPN (vaddr[31:12]) matches a valid entry, and is not blocked by R7 or R8, gives `lk_hit`=1 in the next cycle. In that cycle `lk_paddr` = {PPN, vaddr[11:0]} and `lk_dirty` equals the entry's dirty bit.
- R2: A lookup that matches no valid entry, and is not blocked by R7, gives `lk_miss`=1 for exactly one cycle, in the next cycle. No result flag is ever raised without a request, and at most one of hit, miss, address error and modify exception is high in any cycle.
- R3: The buffer holds 48 entries. A refill whose VPN is already stored overwrites that entry, so at most one entry can ever match a VPN.
- R4: A refill whose VPN is not yet stored goes to the lowest-indexed invalid entry before any valid entry is replaced. Hence 48 distinct refills after a flush are all kept.
- R5: When every entry is valid, a refill with a new VPN replaces the entry with the lowest rank, and the lowest index on a tie.
- R6: Ranks are 3 bits wide. A refill and a hit both set the entry they touch to 7. A hit also lowers the rank of every other valid entry by one, saturating at 0. Misses, address errors and modify exceptions leave all ranks unchanged.
- R7: A request with `lk_user`=1 and vaddr[31]=1 gives `lk_addr_err`=1 in the next cycle, with no hit, no miss and no rank change. In kernel mode (`lk_user`=0) the same address translates normally.
- R8: A write lookup (`lk_write`=1) that hits an entry whose dirty bit is 0 gives `lk_mod_exc`=1 with `lk_hit`=0. A read of that entry, or a write to a dirty entry, is an ordinary hit.
- R9: `flush` invalidates every entry in one cycle. If a refill arrives in the same cycle as a flush, the refill is discarded.
- R10: A lookup and a refill in the same cycle both act on the contents from before that edge. The lookup does not see the entry being written, and the refilled entry ends with rank 7 even if that same lookup aged the other entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties the buffer |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Request is a store |
| lk_user | input | 1 | Request issued in user mode |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | 20 | VPN of the new entry |
| rf_ppn | input | 20 | PPN of the new entry |
| rf_dirty | input | 1 | Dirty bit of the new entry |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | One-cycle miss pulse toward the exception logic |
| lk_addr_err | output | 1 | User access to the kernel half refused |
| lk_mod_exc | output | 1 | Write to a clean page |
| lk_paddr | output | 32 | Physical address, valid with `lk_hit` |
| lk_dirty | output | 1 | Dirty bit of the hit entry |

## Verification
A lookup and a refill can occur in the same cycle. Both then change the rank state: the hit ages its neighbours while the refill writes a slot at full rank. A flush can also coincide with a refill. The bench drives both pairs at the same falling edge. In the lookup-plus-refill case it checks that a lookup for the VPN being written still reports a miss, and that the next lookup hits. In the flush-plus-refill case it checks that the new entry and the older entries both miss afterwards. The replacement order is judged only through later hits and misses at the ports, after hit sequences that leave a known pattern of ranks.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int RANK_W = 3;
    localparam logic [RANK_W-1:0] RANK_MAX = {RANK_W{1'b1}};

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [RANK_W-1:0] rank;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_HIT,
        RES_MISS,
        RES_AERR,
        RES_MOD
    } lk_result_e;

    function automatic logic [RANK_W-1:0] rank_age(input logic [RANK_W-1:0] r);
        return (r == '0) ? '0 : r - 1'b1;
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0] tbl,
    input  logic [VPN_W-1:0]         vpn,
    output logic [ENTRIES-1:0]       match_vec,
    output logic                     match_any,
    output logic [IDX_W-1:0]         match_idx
);
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = tbl[g].valid && (tbl[g].vpn == vpn);
        end
    endgenerate

    assign match_any = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0] tbl,
    input  logic                     dup_any,
    input  logic [IDX_W-1:0]         dup_idx,
    output logic [IDX_W-1:0]         victim_idx
);
    logic              free_found;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  low_idx;
    logic [RANK_W-1:0] low_rank;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!tbl[i].valid && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        low_idx  = '0;
        low_rank = tbl[0].rank;
        for (int i = 1; i < ENTRIES; i++) begin
            if (tbl[i].rank < low_rank) begin
                low_rank = tbl[i].rank;
                low_idx  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (dup_any)         victim_idx = dup_idx;
        else if (free_found) victim_idx = free_idx;
        else                 victim_idx = low_idx;
    end
endmodule

// File: rtl/tlb_ref_lru.sv
module tlb_ref_lru
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_dirty,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_addr_err,
    output logic             lk_mod_exc,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_dirty
);
    tlb_entry_t [ENTRIES-1:0] tbl, tbl_n;

    logic [ENTRIES-1:0] l_vec, r_vec;
    logic               l_any, r_any;
    logic [IDX_W-1:0]   l_idx, r_idx, v_idx;
    lk_result_e         res;
    logic               touch;

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .tbl(tbl), .vpn(lk_vaddr[VA_W-1:OFF_W]),
        .match_vec(l_vec), .match_any(l_any), .match_idx(l_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_rf_match (
        .tbl(tbl), .vpn(rf_vpn),
        .match_vec(r_vec), .match_any(r_any), .match_idx(r_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .tbl(tbl), .dup_any(r_any), .dup_idx(r_idx), .victim_idx(v_idx)
    );

    always_comb begin
        res = RES_NONE;
        if (lk_valid) begin
            if (lk_user && lk_vaddr[VA_W-1])          res = RES_AERR;
            else if (!l_any)                          res = RES_MISS;
            else if (lk_write && !tbl[l_idx].dirty)   res = RES_MOD;
            else                                      res = RES_HIT;
        end
        touch = (res == RES_HIT);
    end

    always_comb begin
        tbl_n = tbl;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == l_idx)  tbl_n[i].rank = RANK_MAX;
                else if (tbl[i].valid)   tbl_n[i].rank = rank_age(tbl[i].rank);
            end
        end
        if (rf_valid) begin
            tbl_n[v_idx].valid = 1'b1;
            tbl_n[v_idx].dirty = rf_dirty;
            tbl_n[v_idx].vpn   = rf_vpn;
            tbl_n[v_idx].ppn   = rf_ppn;
            tbl_n[v_idx].rank  = RANK_MAX;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) tbl_n[i].valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl         <= '0;
            lk_hit      <= 1'b0;
            lk_miss     <= 1'b0;
            lk_addr_err <= 1'b0;
            lk_mod_exc  <= 1'b0;
            lk_paddr    <= '0;
            lk_dirty    <= 1'b0;
        end else begin
            tbl         <= tbl_n;
            lk_hit      <= (res == RES_HIT);
            lk_miss     <= (res == RES_MISS);
            lk_addr_err <= (res == RES_AERR);
            lk_mod_exc  <= (res == RES_MOD);
            if (res == RES_HIT) begin
                lk_paddr <= {tbl[l_idx].ppn, lk_vaddr[OFF_W-1:0]};
                lk_dirty <= tbl[l_idx].dirty;
            end
        end
    end
endmodule

// File: rtl/tlb_ref_lru_chk.sv
module tlb_ref_lru_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     flush,
    input logic                     lk_valid,
    input logic [VA_W-1:0]          lk_vaddr,
    input logic                     lk_user,
    input logic                     lk_hit,
    input logic                     lk_miss,
    input logic                     lk_addr_err,
    input logic                     lk_mod_exc,
    input tlb_entry_t [ENTRIES-1:0] tbl,
    input logic [ENTRIES-1:0]       hit_vec
);
    logic [ENTRIES-1:0] valid_bits;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) valid_bits[i] = tbl[i].valid;
    end

    a_r1_hit_after_request: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> $past(lk_valid));

    a_r2_no_pulse_without_request: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_miss);

    a_r2_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $countones({lk_hit, lk_miss, lk_addr_err, lk_mod_exc}) <= 1);

    a_r3_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    a_r7_kernel_block: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_user && lk_vaddr[VA_W-1]) |=> (lk_addr_err && !lk_hit && !lk_miss));

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_bits == '0));
endmodule

bind tlb_ref_lru tlb_ref_lru_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_user(lk_user), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_addr_err(lk_addr_err), .lk_mod_exc(lk_mod_exc),
    .tbl(tbl), .hit_vec(l_vec)
);

// File: tb/tlb_ref_lru_test.sv
module tlb_ref_lru_test;
    logic        clk = 1'b0;
    logic        rst, flush, lk_valid, lk_write, lk_user, rf_valid, rf_dirty;
    logic [31:0] lk_vaddr;
    logic [19:0] rf_vpn, rf_ppn;
    logic        lk_hit, lk_miss, lk_addr_err, lk_mod_exc, lk_dirty;
    logic [31:0] lk_paddr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tlb_ref_lru uut (
        .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_dirty(rf_dirty),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_addr_err(lk_addr_err),
        .lk_mod_exc(lk_mod_exc), .lk_paddr(lk_paddr), .lk_dirty(lk_dirty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one lookup; results sampled at the next falling edge
    task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                          input logic wr, input logic usr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr; lk_user = usr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0; lk_user = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic d);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_dirty = d;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic logic [3:0] flags();
        return {lk_hit, lk_miss, lk_addr_err, lk_mod_exc};
    endfunction

    task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [19:0] ppn);
        lookup(vpn, 12'h3C4, 1'b0, 1'b0);
        check(req, {28'd0, flags()}, 32'h8);
        check(req, lk_paddr, {ppn, 12'h3C4});
    endtask

    task automatic expect_miss(input string req, input logic [19:0] vpn);
        lookup(vpn, 12'h000, 1'b0, 1'b0);
        check(req, {28'd0, flags()}, 32'h4);
    endtask

    task automatic t_reset();
        check("R2 reset", {28'd0, flags()}, 32'h0);
        expect_miss("R2 empty miss", 20'h00123);
        @(negedge clk);
        check("R2 miss single cycle", {31'd0, lk_miss}, 32'd0);
    endtask

    task automatic t_fill_and_rank();
        do_flush();
        for (int i = 0; i < 48; i++) refill(20'h10 + 20'(i), 20'h300 + 20'(i), 1'b1);
        // every entry kept (R4, R3 capacity); hits walk 47 down to 0
        for (int i = 47; i >= 0; i--) begin
            lookup(20'h10 + 20'(i), 12'h055, 1'b0, 1'b0);
            check("R4 all 48 kept", {31'd0, lk_hit}, 32'd1);
            check("R1 paddr", lk_paddr, {20'h300 + 20'(i), 12'h055});
        end
        // ranks now: idx0=7, idx1=6 ... idx6=1, idx7 and above 0
        refill(20'h500, 20'h777, 1'b1);
        expect_miss("R5 lowest rank evicted (idx7)", 20'h17);
        expect_hit("R5 new entry present", 20'h500, 20'h777);
        expect_hit("R6 recently hit entry kept", 20'h16, 20'h306);
        expect_hit("R6 saturated entry kept", 20'h18, 20'h308);
    endtask

    task automatic t_duplicate();
        do_flush();
        refill(20'h700, 20'h111, 1'b1);
        refill(20'h700, 20'h222, 1'b1);
        expect_hit("R3 overwrite same vpn", 20'h700, 20'h222);
    endtask

    task automatic t_kernel();
        refill(20'h80001, 20'h0ABC, 1'b1);
        lookup(20'h80001, 12'h010, 1'b0, 1'b1);
        check("R7 user kernel blocked", {28'd0, flags()}, 32'h2);
        lookup(20'h80077, 12'h010, 1'b0, 1'b1);
        check("R7 unmapped kernel: error not miss", {28'd0, flags()}, 32'h2);
        lookup(20'h80001, 12'h010, 1'b0, 1'b0);
        check("R7 kernel mode translates", {28'd0, flags()}, 32'h8);
        check("R7 kernel paddr", lk_paddr, {20'h0ABC, 12'h010});
    endtask

    task automatic t_modify();
        refill(20'h42, 20'h999, 1'b0);
        lookup(20'h42, 12'h004, 1'b1, 1'b0);
        check("R8 write to clean page", {28'd0, flags()}, 32'h1);
        lookup(20'h42, 12'h004, 1'b0, 1'b0);
        check("R8 read of clean page", {28'd0, flags()}, 32'h8);
        check("R8 dirty bit out", {31'd0, lk_dirty}, 32'd0);
        lookup(20'h700, 12'h004, 1'b1, 1'b0);
        check("R8 write to dirty page", {28'd0, flags()}, 32'h8);
        check("R8 dirty bit set", {31'd0, lk_dirty}, 32'd1);
    endtask

    task automatic t_same_cycle();
        do_flush();
        refill(20'h710, 20'h010, 1'b1);
        // lookup and refill of the same VPN in one cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {20'h800, 12'h0}; lk_write = 1'b0; lk_user = 1'b0;
        rf_valid = 1'b1; rf_vpn = 20'h800; rf_ppn = 20'h808; rf_dirty = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; rf_valid = 1'b0;
        check("R10 lookup sees old contents", {28'd0, flags()}, 32'h4);
        expect_hit("R10 refill landed", 20'h800, 20'h808);
        // flush and refill together
        @(negedge clk);
        flush = 1'b1; rf_valid = 1'b1; rf_vpn = 20'h900; rf_ppn = 20'h909; rf_dirty = 1'b1;
        @(negedge clk);
        flush = 1'b0; rf_valid = 1'b0;
        expect_miss("R9 refill dropped under flush", 20'h900);
        expect_miss("R9 old entry flushed", 20'h710);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; lk_valid = 1'b0; lk_write = 1'b0; lk_user = 1'b0;
        lk_vaddr = '0; rf_valid = 1'b0; rf_vpn = '0; rf_ppn = '0; rf_dirty = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_and_rank();
        t_duplicate();
        t_kernel();
        t_modify();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule